// File: doc/BRIEF.md
# Programmable High/Low Phase Clock Divider

The block derives an output clock from a fast reference clock. One 8-bit setting gives the length of the high phase and the length of the low phase separately. Each phase length is a 4-bit field that holds the number of reference cycles minus one. The two phases can differ, so the duty cycle can be uneven, and the output period is the sum of the two phase lengths. A counter steps through the reference cycles of each phase and flips the output at each phase boundary.

Software writes a new setting through a write strobe. The setting is first held as pending. It is applied only where one output period ends and the next begins, so the output never shows a shortened phase. A low-power select replaces the divided clock at the output with an always-on slow clock. That selection passes through one reference-clock register. The divider keeps counting underneath, so the divided clock is ready again as soon as the selection is released. The registered selection plus a 2-way mux stands in for a proper clock-switch cell.

Top module: `hl_clk_div`

## Requirements
- R1: While reset is asserted, the output is low. After reset is released, the active setting is 0x00, and the first phase is a low phase one reference cycle long, followed by a high phase one cycle long.
- R2: The high phase lasts (setting[7:4] + 1) reference cycles.
- R3: The low phase lasts (setting[3:0] + 1) reference cycles.
- R4: The output period is the sum of the two phase lengths. Setting 0x00 divides the reference by 2. Setting 0x54 gives 6 cycles high and 5 cycles low, which divides by 11.
- R5: Nibble pairs that differ by more than one cycle run exactly as programmed. For example, 0xF0 gives 16 cycles high and 1 cycle low.
- R6: The setting input is captured only on a reference edge where the write strobe is high. Without the strobe, changes on the setting input have no effect on the output phases.
- R7: A setting written in the middle of a period does not change that period. The current low and high phases finish with the old lengths, and the new lengths start with the next period.
- R8: Every output period begins with its low phase. A new setting is applied at the falling edge of the output, which is the end of a high phase.
- R9: One reference edge after the low-power select is sampled high, the output equals the slow clock input. The divider keeps running during this time. One reference edge after the select is sampled low, the output again shows the divided clock with the active phase lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_clk_i | input | 1 | Always-on slow clock used in low-power mode |
| cfg_i | input | 8 | Phase setting: [7:4] high length minus one, [3:0] low length minus one |
| cfg_we_i | input | 1 | Write strobe for cfg_i |
| lp_sel_i | input | 1 | Selects the slow clock at the output when high |
| clk_o | output | 1 | Output clock |

## Verification
The hardest case to reach is a write that lands part way through a period. To show that the old lengths finish, the new setting must arrive while a phase is still running. The bench first lines up on a falling edge of the output with the slowest setting, 0xFF, active. It then writes 0x00 one cycle into that low phase. It checks that this period still lasts 16 cycles low and 16 cycles high, and that the next period is 1 low and 1 high. The full sweep of all 256 settings measures each phase from the second period after the write. This guarantees that the setting has been loaded, whichever phase the write arrived in.

// File: rtl/hl_clk_div_pkg.sv
`timescale 1ns/1ps
package hl_clk_div_pkg;
  parameter int unsigned NIB_W = 4;
  localparam int unsigned CFG_W = 2 * NIB_W;

  typedef struct packed {
    logic [NIB_W-1:0] hi;  // high length minus one
    logic [NIB_W-1:0] lo;  // low length minus one
  } phase_cfg_t;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;
endpackage

// File: rtl/hl_clk_div_cfg.sv
`timescale 1ns/1ps
module hl_clk_div_cfg
  import hl_clk_div_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  phase_cfg_t wdata_i,
  input  logic       period_end_i,
  output phase_cfg_t active_o
);
  phase_cfg_t pend_q, active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else if (wr_i) begin
      pend_q <= wdata_i;
    end
  end

  // apply only where one period ends and the next begins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= '0;
    end else if (period_end_i) begin
      active_q <= pend_q;
    end
  end

  assign active_o = active_q;

  AST_CFG_AT_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(active_q) |-> $past(period_end_i)); // R7

endmodule

// File: rtl/hl_clk_div_phase.sv
`timescale 1ns/1ps
module hl_clk_div_phase
  import hl_clk_div_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  phase_cfg_t cfg_i,
  output logic       div_o,
  output logic       period_end_o
);
  phase_e           phase_q;
  logic [NIB_W-1:0] cnt_q;
  logic [NIB_W-1:0] lim;
  logic             last;

  assign lim          = (phase_q == PH_HIGH) ? cfg_i.hi : cfg_i.lo;
  assign last         = (cnt_q == lim);
  assign period_end_o = last && (phase_q == PH_HIGH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_LOW;
      cnt_q   <= '0;
    end else if (last) begin
      phase_q <= (phase_q == PH_HIGH) ? PH_LOW : PH_HIGH;
      cnt_q   <= '0;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign div_o = (phase_q == PH_HIGH);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim); // R2
  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(div_o) |-> cnt_q == '0); // R8
  AST_HIGH_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(div_o) |-> $past(cnt_q) == $past(cfg_i.hi)); // R2
  AST_LOW_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_o) |-> $past(cnt_q) == $past(cfg_i.lo)); // R3

endmodule

// File: rtl/hl_clk_div_outsel.sv
`timescale 1ns/1ps
module hl_clk_div_outsel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lp_sel_i,
  input  logic slow_clk_i,
  input  logic div_i,
  output logic clk_o
);
  logic lp_q;

  // registered select stands in for a glitch-free switch cell
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lp_q <= 1'b0;
    else         lp_q <= lp_sel_i;
  end

  assign clk_o = lp_q ? slow_clk_i : div_i;

endmodule

// File: rtl/hl_clk_div.sv
`timescale 1ns/1ps
module hl_clk_div
  import hl_clk_div_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slow_clk_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             cfg_we_i,
  input  logic             lp_sel_i,
  output logic             clk_o
);
  phase_cfg_t active;
  logic       period_end;
  logic       div_clk;

  hl_clk_div_cfg u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (cfg_we_i),
    .wdata_i      (phase_cfg_t'(cfg_i)),
    .period_end_i (period_end),
    .active_o     (active)
  );

  hl_clk_div_phase u_phase (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_i        (active),
    .div_o        (div_clk),
    .period_end_o (period_end)
  );

  hl_clk_div_outsel u_outsel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lp_sel_i   (lp_sel_i),
    .slow_clk_i (slow_clk_i),
    .div_i      (div_clk),
    .clk_o      (clk_o)
  );

endmodule

// File: tb/tb_hl_clk_div.sv
`timescale 1ns/1ps
module tb_hl_clk_div;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       slow_clk_i = 1'b0;
  logic [7:0] cfg_i = 8'h00;
  logic       cfg_we_i = 1'b0;
  logic       lp_sel_i = 1'b0;
  logic       clk_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  hl_clk_div dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slow_clk_i (slow_clk_i),
    .cfg_i      (cfg_i),
    .cfg_we_i   (cfg_we_i),
    .lp_sel_i   (lp_sel_i),
    .clk_o      (clk_o)
  );

  always #2.5 clk_i = ~clk_i;   // 200 MHz
  always #37  slow_clk_i = ~slow_clk_i;

  task automatic check(input int act, input int exp, input string req, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // wait at negedges for a 1 -> 0 transition of clk_o
  task automatic sync_fall();
    logic prev;
    prev = clk_o;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_i);
      if (prev && !clk_o) return;
      prev = clk_o;
    end
  endtask

  // count samples equal to v, starting with the current one
  task automatic run_len(input logic v, output int n);
    n = 0;
    while (clk_o == v && n < 100) begin
      n++;
      @(negedge clk_i);
    end
  endtask

  task automatic measure(output int lo, output int hi);
    sync_fall();
    run_len(1'b0, lo);
    run_len(1'b1, hi);
  endtask

  task automatic write_cfg(input logic [7:0] v);
    cfg_i    = v;
    cfg_we_i = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  initial begin
    int lo, hi, n;
    repeat (3) @(negedge clk_i);
    check(int'(clk_o), 0, "R1", "output in reset");
    rst_ni = 1'b1;
    run_len(1'b0, n);
    check(n, 1, "R1", "first low phase after reset");
    run_len(1'b1, n);
    check(n, 1, "R1", "first high phase after reset");
    measure(lo, hi);
    check(lo + hi, 2, "R4", "reset setting divides by 2");

    // R4: named example settings
    write_cfg(8'h54);
    measure(lo, hi); measure(lo, hi);
    check(hi, 6, "R4", "0x54 high");
    check(lo, 5, "R4", "0x54 low");
    check(lo + hi, 11, "R4", "0x54 period");

    // R5: strongly uneven pairs
    write_cfg(8'hF0);
    measure(lo, hi); measure(lo, hi);
    check(hi, 16, "R5", "0xF0 high");
    check(lo, 1, "R5", "0xF0 low");
    write_cfg(8'h0E);
    measure(lo, hi); measure(lo, hi);
    check(hi, 1, "R5", "0x0E high");
    check(lo, 15, "R5", "0x0E low");

    // R6: setting input moves without strobe
    write_cfg(8'h32);
    measure(lo, hi); measure(lo, hi);
    cfg_i = 8'hAB;
    measure(lo, hi); measure(lo, hi);
    check(hi, 4, "R6", "high unchanged without strobe");
    check(lo, 3, "R6", "low unchanged without strobe");
    cfg_i = 8'h00;

    // R7/R8: write one cycle into a low phase of 0xFF
    write_cfg(8'hFF);
    measure(lo, hi); measure(lo, hi);
    sync_fall();
    cfg_i = 8'h00; cfg_we_i = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    run_len(1'b0, n);
    check(n + 1, 16, "R7", "low phase completes with old length");
    run_len(1'b1, n);
    check(n, 16, "R7", "high phase completes with old length");
    run_len(1'b0, n);
    check(n, 1, "R8", "new period starts with new low");
    run_len(1'b1, n);
    check(n, 1, "R8", "new period high");

    // R9: low-power select
    write_cfg(8'h21);
    measure(lo, hi); measure(lo, hi);
    lp_sel_i = 1'b1;
    @(negedge clk_i); @(negedge clk_i);
    for (int i = 0; i < 40; i++) begin
      #1.3;
      check(int'(clk_o), int'(slow_clk_i), "R9", "output follows slow clock");
      @(negedge clk_i);
    end
    lp_sel_i = 1'b0;
    @(negedge clk_i); @(negedge clk_i);
    measure(lo, hi);
    check(hi, 3, "R9", "divided high after leaving low power");
    check(lo, 2, "R9", "divided low after leaving low power");

    // R2/R3: every setting
    for (int s = 0; s < 256; s++) begin
      write_cfg(s[7:0]);
      measure(lo, hi); measure(lo, hi);
      check(hi, (s >> 4) + 1, "R2", $sformatf("high length for 0x%02h", s));
      check(lo, (s & 15) + 1, "R3", $sformatf("low length for 0x%02h", s));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule